// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block keeps the status byte of a UART-style serial channel. It holds three live flags. The transmit-empty flag shows that the transmit holding byte has been taken and a new byte may be written. The receive-full flag shows that the receive holding register contains a byte that has not been consumed. The overrun flag records that a clean reception finished while the previous byte was still unread. The block does not move or shift any data. It takes single-cycle event strobes from the transmit and receive datapaths and from a DMA engine, plus the transmitter-enable level and a standby level. It gives out the status byte and a strobe, `rx_accept_o`, that tells the receive datapath whether to copy its shift register into the holding register.

Each flag is a three-state machine of type `flag_state_e`. `FLAG_LOW` means the flag is 0. `FLAG_HIGH` means the flag is 1 and no processor read has seen it yet. `FLAG_ARMED` means the flag is 1 and the processor has read it as 1. The transitions are:

- `LOW->HIGH` on a set event.
- `HIGH->ARMED` on a processor read with no write in the same cycle.
- `HIGH->LOW` and `ARMED->LOW` on a hardware clear with no set in the same cycle.
- `ARMED->LOW` on a processor write of 0.
- `ARMED->HIGH` on a processor write of 1, which uses up the arming.
- Any state goes to its reset state on reset or standby.

The processor can clear a flag only from `FLAG_ARMED`. A set event always beats a clear in the same cycle. The register resets to 0x84, and the bits below the flags read as the constant 00100.

Top module: `sci_status_flags`

## Requirements
- R1: When synchronous reset (`rst_n` low) or standby is active at a clock edge, `status_o` becomes 0x84. Bit 7 is transmit-empty, bit 6 is receive-full, bit 5 is overrun, and bits 4..0 always read 00100.
- R2: A holding-to-shift transfer strobe (`tx_load_i`) sets bit 7 at the next edge.
- R3: While `tx_enable_i` is 0, bit 7 is forced to 1. Neither a processor clear nor a DMA write can lower it.
- R4: A clean reception (`rx_done_i` high, `rx_err_i` low) while bit 6 is 0 raises `rx_accept_o` in the same cycle and sets bit 6 at the next edge.
- R5: A processor write of 0 to a flag clears it only if a processor read saw that flag at 1 after the flag was last raised. Without such a read the write has no effect.
- R6: A processor write of 1 to an armed flag leaves the flag at 1 and uses up the arming, so a later write of 0 has no effect.
- R7: A DMA write to the transmit holding register clears bit 7. A DMA read of the receive holding register clears bit 6.
- R8: When a set event and a clear event for the same flag fall in the same cycle, the flag ends at 1.
- R9: A reception marked with `rx_err_i` changes no flag and keeps `rx_accept_o` at 0.
- R10: A clean reception while bit 6 is 1 sets bit 5, keeps bit 6 at 1, and keeps `rx_accept_o` at 0, so the new byte is dropped.
- R11: Bit 5 is cleared only by the processor read-then-write-0 rule. DMA accesses do not clear it.
- R12: A flag that is lowered by hardware loses its arming. After it is raised again, a processor write of 0 without a fresh read has no effect.
- R13: A single write clears only the armed flags whose write bit is 0. The other flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| standby_i | input | 1 | Standby level; acts as a synchronous reset of the flags |
| tx_enable_i | input | 1 | Transmitter enable level; 0 forces transmit-empty |
| tx_load_i | input | 1 | Strobe: holding byte moved into the transmit shifter |
| rx_done_i | input | 1 | Strobe: a reception has completed |
| rx_err_i | input | 1 | Qualifies `rx_done_i`: the reception had an error |
| dma_tx_wr_i | input | 1 | Strobe: DMA wrote the transmit holding register |
| dma_rx_rd_i | input | 1 | Strobe: DMA read the receive holding register |
| cpu_rd_i | input | 1 | Strobe: processor read of the status byte |
| cpu_wr_i | input | 1 | Strobe: processor write of the status byte |
| cpu_wflags_i | input | 3 | Write data for status bits 7..5 (bit 2 goes to bit 7) |
| status_o | output | 8 | Status byte |
| rx_accept_o | output | 1 | Copy the received byte into the holding register |

## Verification
The hardest situations to reach from the ports are those that depend on the hidden arming, because the status byte shows `FLAG_HIGH` and `FLAG_ARMED` as the same 1. The stimulus first drives each flag into a chosen start state: low, raised but unread, or raised and read. It then applies every combination of set strobe, hardware clear, read, write and write bit. After that it sends a plain write of 0 as a probe. Whether the probe clears the flag shows the arming that the combination left behind. Overrun, error receptions and the transmitter-disable override are then covered by directed sequences.

// File: rtl/sci_flag_pkg.sv
package sci_flag_pkg;

    // Number of live flags and their index within the flag vector.
    localparam int NFLAG   = 3;
    localparam int IDX_OVR = 0;
    localparam int IDX_RXF = 1;
    localparam int IDX_TXE = 2;

    // Per-flag state: cleared, raised but unseen, raised and seen by a read.
    typedef enum logic [1:0] {
        FLAG_LOW   = 2'b00,
        FLAG_HIGH  = 2'b01,
        FLAG_ARMED = 2'b10
    } flag_state_e;

endpackage

// File: rtl/sci_flag_fsm.sv
module sci_flag_fsm
    import sci_flag_pkg::*;
#(
    parameter bit RESET_HIGH = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby_i,
    input  logic set_i,
    input  logic hw_clr_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wr_bit_i,
    output logic flag_o,
    output logic armed_o
);

    localparam flag_state_e RST_STATE = RESET_HIGH ? FLAG_HIGH : FLAG_LOW;

    flag_state_e state_q;
    flag_state_e state_d;

    // Next-state logic: a set beats any clear; a processor clear needs arming.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_LOW: begin
                if (set_i) state_d = FLAG_HIGH;
            end
            FLAG_HIGH: begin
                if (hw_clr_i && !set_i)    state_d = FLAG_LOW;
                else if (rd_i && !wr_i)    state_d = FLAG_ARMED;
                else                       state_d = FLAG_HIGH;
            end
            FLAG_ARMED: begin
                if (set_i)                 state_d = wr_i ? FLAG_HIGH : FLAG_ARMED;
                else if (hw_clr_i)         state_d = FLAG_LOW;
                else if (wr_i)             state_d = wr_bit_i ? FLAG_HIGH : FLAG_LOW;
                else                       state_d = FLAG_ARMED;
            end
            default: state_d = RST_STATE;
        endcase
    end

    // State register with synchronous reset; standby behaves like reset.
    always_ff @(posedge clk) begin
        if (!rst_n || standby_i) state_q <= RST_STATE;
        else                     state_q <= state_d;
    end

    // Outputs decoded from the current state.
    always_comb begin
        flag_o  = 1'b0;
        armed_o = 1'b0;
        unique case (state_q)
            FLAG_LOW:   begin flag_o = 1'b0; armed_o = 1'b0; end
            FLAG_HIGH:  begin flag_o = 1'b1; armed_o = 1'b0; end
            FLAG_ARMED: begin flag_o = 1'b1; armed_o = 1'b1; end
            default:    begin flag_o = 1'b0; armed_o = 1'b0; end
        endcase
    end

endmodule

// File: rtl/sci_flag_events.sv
module sci_flag_events
    import sci_flag_pkg::*;
(
    input  logic             tx_enable_i,
    input  logic             tx_load_i,
    input  logic             rx_done_i,
    input  logic             rx_err_i,
    input  logic             dma_tx_wr_i,
    input  logic             dma_rx_rd_i,
    input  logic [NFLAG-1:0] flags_i,
    output logic [NFLAG-1:0] set_o,
    output logic [NFLAG-1:0] hw_clr_o,
    output logic             rx_accept_o
);

    logic rx_clean;
    logic rx_full;

    assign rx_clean = rx_done_i && !rx_err_i;
    assign rx_full  = flags_i[IDX_RXF];

    always_comb begin
        set_o    = '0;
        hw_clr_o = '0;
        // Transmit-empty: shifter load or transmitter disabled; DMA write clears.
        set_o[IDX_TXE]    = tx_load_i || !tx_enable_i;
        hw_clr_o[IDX_TXE] = dma_tx_wr_i;
        // Receive-full: clean reception; DMA read clears.
        set_o[IDX_RXF]    = rx_clean;
        hw_clr_o[IDX_RXF] = dma_rx_rd_i;
        // Overrun: clean reception while the holding register is still full.
        set_o[IDX_OVR]    = rx_clean && rx_full;
        hw_clr_o[IDX_OVR] = 1'b0;
    end

    assign rx_accept_o = rx_clean && !rx_full;

endmodule

// File: rtl/sci_status_flags.sv
module sci_status_flags
    import sci_flag_pkg::*;
#(
    parameter int          DATA_W    = 8,
    parameter int          FLAG_LSB  = 5,
    parameter logic [7:0]  RESET_VAL = 8'h84
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_i,
    input  logic              tx_enable_i,
    input  logic              tx_load_i,
    input  logic              rx_done_i,
    input  logic              rx_err_i,
    input  logic              dma_tx_wr_i,
    input  logic              dma_rx_rd_i,
    input  logic              cpu_rd_i,
    input  logic              cpu_wr_i,
    input  logic [NFLAG-1:0]  cpu_wflags_i,
    output logic [DATA_W-1:0] status_o,
    output logic              rx_accept_o
);

    localparam int FLAG_MSB = FLAG_LSB + NFLAG - 1;
    localparam logic [DATA_W-1:0] FLAG_MASK =
        DATA_W'(((1 << NFLAG) - 1) << FLAG_LSB);
    localparam logic [DATA_W-1:0] FIXED_BITS = DATA_W'(RESET_VAL) & ~FLAG_MASK;

    logic [NFLAG-1:0] flags;
    logic [NFLAG-1:0] armed;
    logic [NFLAG-1:0] set_ev;
    logic [NFLAG-1:0] clr_ev;

    sci_flag_events u_events (
        .tx_enable_i (tx_enable_i),
        .tx_load_i   (tx_load_i),
        .rx_done_i   (rx_done_i),
        .rx_err_i    (rx_err_i),
        .dma_tx_wr_i (dma_tx_wr_i),
        .dma_rx_rd_i (dma_rx_rd_i),
        .flags_i     (flags),
        .set_o       (set_ev),
        .hw_clr_o    (clr_ev),
        .rx_accept_o (rx_accept_o)
    );

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        sci_flag_fsm #(
            .RESET_HIGH (RESET_VAL[FLAG_LSB + i])
        ) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .standby_i (standby_i),
            .set_i     (set_ev[i]),
            .hw_clr_i  (clr_ev[i]),
            .rd_i      (cpu_rd_i),
            .wr_i      (cpu_wr_i),
            .wr_bit_i  (cpu_wflags_i[i]),
            .flag_o    (flags[i]),
            .armed_o   (armed[i])
        );
    end

    // The arming state is internal; it has no path to the ports.
    logic armed_unused;
    assign armed_unused = ^armed;

    always_comb begin
        status_o                    = FIXED_BITS;
        status_o[FLAG_MSB:FLAG_LSB] = flags;
    end

endmodule

// File: rtl/sci_status_flags_chk.sv
module sci_status_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       standby_i,
    input logic       tx_enable_i,
    input logic       tx_load_i,
    input logic       rx_done_i,
    input logic       rx_err_i,
    input logic       dma_rx_rd_i,
    input logic       cpu_wr_i,
    input logic [7:0] status_o,
    input logic       rx_accept_o
);

    assert_reset_val_R1: assert property (@(posedge clk)
        (!rst_n || standby_i) |=> (status_o == 8'h84));

    assert_tx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load_i && !standby_i) |=> status_o[7]);

    assert_tx_force_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_enable_i && !standby_i) |=> status_o[7]);

    assert_rx_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_i && !rx_err_i && !status_o[6]) |-> rx_accept_o);

    assert_rx_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_i && !rx_err_i && !standby_i) |=> status_o[6]);

    assert_dma_rx_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rx_rd_i && !(rx_done_i && !rx_err_i)) |=> !status_o[6]);

    assert_err_no_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err_i |-> !rx_accept_o);

    assert_overrun_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_i && status_o[6]) |-> !rx_accept_o);

    assert_overrun_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_i && !rx_err_i && status_o[6] && !standby_i)
            |=> (status_o[5] && status_o[6]));

    assert_ovr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[5] && !cpu_wr_i && !standby_i) |=> status_o[5]);

endmodule

bind sci_status_flags sci_status_flags_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .standby_i   (standby_i),
    .tx_enable_i (tx_enable_i),
    .tx_load_i   (tx_load_i),
    .rx_done_i   (rx_done_i),
    .rx_err_i    (rx_err_i),
    .dma_rx_rd_i (dma_rx_rd_i),
    .cpu_wr_i    (cpu_wr_i),
    .status_o    (status_o),
    .rx_accept_o (rx_accept_o)
);

// File: tb/tb_sci_status_flags.sv
module tb_sci_status_flags;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby_i = 1'b0;
    logic       tx_enable_i = 1'b1;
    logic       tx_load_i = 1'b0;
    logic       rx_done_i = 1'b0;
    logic       rx_err_i = 1'b0;
    logic       dma_tx_wr_i = 1'b0;
    logic       dma_rx_rd_i = 1'b0;
    logic       cpu_rd_i = 1'b0;
    logic       cpu_wr_i = 1'b0;
    logic [2:0] cpu_wflags_i = 3'b111;
    logic [7:0] status_o;
    logic       rx_accept_o;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    sci_status_flags dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .standby_i    (standby_i),
        .tx_enable_i  (tx_enable_i),
        .tx_load_i    (tx_load_i),
        .rx_done_i    (rx_done_i),
        .rx_err_i     (rx_err_i),
        .dma_tx_wr_i  (dma_tx_wr_i),
        .dma_rx_rd_i  (dma_rx_rd_i),
        .cpu_rd_i     (cpu_rd_i),
        .cpu_wr_i     (cpu_wr_i),
        .cpu_wflags_i (cpu_wflags_i),
        .status_o     (status_o),
        .rx_accept_o  (rx_accept_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: inputs already set are taken at the edge, then strobes drop.
    task automatic tick();
        @(posedge clk);
        #2;
        tx_load_i = 0; rx_done_i = 0; rx_err_i = 0;
        dma_tx_wr_i = 0; dma_rx_rd_i = 0;
        cpu_rd_i = 0; cpu_wr_i = 0; cpu_wflags_i = 3'b111;
    endtask

    task automatic do_reset();
        rst_n = 0; tick(); rst_n = 1;
    endtask

    task automatic cpu_write(input logic [2:0] v);
        cpu_wr_i = 1; cpu_wflags_i = v; tick();
    endtask

    task automatic cpu_read();
        cpu_rd_i = 1; tick();
    endtask

    // Expected next state: 0 low, 1 raised unseen, 2 raised and read.
    function automatic int nxt(int st, bit s, bit c, bit r, bit w, bit b);
        case (st)
            0: return s ? 1 : 0;
            1: begin
                if (c && !s) return 0;
                return (r && !w) ? 2 : 1;
            end
            default: begin
                if (s) return w ? 1 : 2;
                if (c) return 0;
                if (w) return b ? 1 : 0;
                return 2;
            end
        endcase
    endfunction

    // Sweep: fl 0 = transmit-empty (bit 7), 1 = receive-full (bit 6).
    task automatic sweep(input int fl);
        for (int st = 0; st < 3; st++) begin
            for (int cmb = 0; cmb < 32; cmb++) begin
                bit s, c, r, w, b;
                int en;
                int bitpos;
                s = cmb[0]; c = cmb[1]; r = cmb[2]; w = cmb[3]; b = cmb[4];
                bitpos = (fl == 0) ? 7 : 6;
                do_reset();
                if (fl == 0) begin
                    if (st == 0) begin cpu_read(); cpu_write(3'b000); end
                    if (st == 2) cpu_read();
                end else begin
                    if (st >= 1) begin rx_done_i = 1; tick(); end
                    if (st == 2) cpu_read();
                end
                if (fl == 0) begin tx_load_i = s; dma_tx_wr_i = c; end
                else         begin rx_done_i = s; dma_rx_rd_i = c; end
                cpu_rd_i = r; cpu_wr_i = w;
                cpu_wflags_i = (fl == 0) ? {b, 2'b11} : {1'b1, b, 1'b1};
                tick();
                en = nxt(st, s, c, r, w, b);
                chk($sformatf("R5/R6/R7/R8 sweep flag%0d st%0d cmb%0d", fl, st, cmb),
                    32'(status_o[bitpos]), 32'(en != 0));
                cpu_write(3'b000);
                chk($sformatf("R5/R12 arming probe flag%0d st%0d cmb%0d", fl, st, cmb),
                    32'(status_o[bitpos]), 32'(en == 1));
            end
        end
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        #5;
        do_reset();
        // R1 reset value
        chk("R1 reset value", 32'(status_o), 32'h84);
        chk("R1 no accept idle", 32'(rx_accept_o), 32'h0);

        // R5 write 0 with no read has no effect
        cpu_write(3'b000);
        chk("R5 unarmed write", 32'(status_o), 32'h84);
        // R6 write 1 consumes arming
        cpu_read(); cpu_write(3'b111); cpu_write(3'b000);
        chk("R6 arming consumed", 32'(status_o), 32'h84);
        // R5 read then write 0 clears
        cpu_read(); cpu_write(3'b000);
        chk("R5 armed clear", 32'(status_o), 32'h04);
        // R2 shifter load sets transmit-empty
        tx_load_i = 1; tick();
        chk("R2 load sets", 32'(status_o), 32'h84);
        // R7 DMA write clears; R12 arming lost
        cpu_read(); dma_tx_wr_i = 1; tick();
        chk("R7 dma tx clear", 32'(status_o), 32'h04);
        tx_load_i = 1; tick(); cpu_write(3'b000);
        chk("R12 arming dropped", 32'(status_o), 32'h84);

        // R4 clean reception
        rx_done_i = 1; #1;
        chk("R4 accept strobe", 32'(rx_accept_o), 32'h1);
        tick();
        chk("R4 receive-full set", 32'(status_o), 32'hC4);
        // R9 error reception
        rx_done_i = 1; rx_err_i = 1; #1;
        chk("R9 error no accept", 32'(rx_accept_o), 32'h0);
        tick();
        chk("R9 error no flag change", 32'(status_o), 32'hC4);
        // R10 overrun
        rx_done_i = 1; #1;
        chk("R10 byte dropped", 32'(rx_accept_o), 32'h0);
        tick();
        chk("R10 overrun set", 32'(status_o), 32'hE4);
        // R7 DMA read clears receive-full; R11 overrun survives DMA
        dma_rx_rd_i = 1; dma_tx_wr_i = 1; tick();
        chk("R7/R11 dma clears", 32'(status_o), 32'h24);
        // R13 selective clear
        tx_load_i = 1; tick();
        cpu_read(); cpu_write(3'b110);
        chk("R11/R13 overrun only", 32'(status_o), 32'h84);
        cpu_write(3'b000);
        chk("R13 other arming consumed", 32'(status_o), 32'h84);
        // R8 set beats processor clear
        cpu_read(); tx_load_i = 1; cpu_wr_i = 1; cpu_wflags_i = 3'b000; tick();
        chk("R8 set wins", 32'(status_o), 32'h84);
        rx_done_i = 1; tick(); dma_rx_rd_i = 1; rx_done_i = 1; tick();
        chk("R8 rx set beats dma", 32'(status_o[6]), 32'h1);
        dma_rx_rd_i = 1; tick();
        // R3 transmitter disabled
        tx_enable_i = 0;
        cpu_read(); cpu_write(3'b000);
        chk("R3 cpu clear blocked", 32'(status_o[7]), 32'h1);
        dma_tx_wr_i = 1; tick();
        chk("R3 dma clear blocked", 32'(status_o[7]), 32'h1);
        tx_enable_i = 1;
        // R1 standby
        rx_done_i = 1; tick(); rx_done_i = 1; tick();
        chk("R1 pre-standby", 32'(status_o), 32'hE4);
        standby_i = 1; rx_done_i = 1; tick();
        chk("R1 standby value", 32'(status_o), 32'h84);
        standby_i = 0;

        sweep(0);
        sweep(1);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule